// File: doc/BRIEF.md
# Branch Condition and Annul Unit

This block resolves a conditional branch in the decode stage of a pipelined integer core. Each cycle it receives a four-bit condition selector, the annul bit and a marker that says the current instruction is a conditional branch. It also receives two four-bit flag sets (negative, zero, overflow, carry) and a selector that chooses between them. The first set is written by integer ALU operations. The second is a separate set, written by a floating-point or coprocessor unit. The block evaluates the selected condition against the chosen flags and reports whether the branch is taken.

The block also decides whether the instruction in the delay slot must be squashed. With annul clear, the delay slot always runs. With annul set, the delay slot runs only when the branch is taken. Branch-always with annul set is the exception: the branch is taken and the delay slot is still squashed.

In parallel, the block forms the branch target by adding the sign-extended 22-bit word displacement, scaled to bytes, to the branch PC. All three results are registered, so they are valid one clock after the inputs.

Top module: `brc_unit`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, taken, annul_next and target are all zero.
- R2: The results for inputs presented in one cycle appear on the outputs after the next rising clock edge. taken and annul_next are 0 whenever is_branch was 0.
- R3: Flag bits are ordered bit 3 = negative (N), bit 2 = zero (Z), bit 1 = overflow (V), bit 0 = carry (C). The condition codes 0 to 7 mean, in order: never, Z, Z|(N^V), N^V, C|Z, C, N, V.
- R4: Codes 8 to 15 are the logical negation of the code 8 below them: always, not-equal, greater, greater-or-equal, greater-unsigned, carry-clear, positive, overflow-clear.
- R5: With annul_bit = 0, annul_next is 0.
- R6: With annul_bit = 1 and the branch not taken (including code 0, never), annul_next is 1.
- R7: With annul_bit = 1 and the branch taken by any code other than 8, annul_next is 0.
- R8: Code 8 with annul_bit = 1 gives taken = 1 and annul_next = 1.
- R9: With use_alt = 1 the condition is tested against alt_flags and int_flags has no effect. With use_alt = 0 the reverse holds.
- R10: target equals pc plus the sign-extended disp shifted left by two, modulo 2^ADDR_W, whether or not the instruction is a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_branch | input | 1 | Current instruction is a conditional branch |
| cond_sel | input | 4 | Condition code |
| annul_bit | input | 1 | Annul bit of the branch |
| use_alt | input | 1 | Test alt_flags instead of int_flags |
| int_flags | input | 4 | Integer flags {N,Z,V,C} |
| alt_flags | input | 4 | Separate flag set {N,Z,V,C} |
| pc | input | ADDR_W | Address of the branch |
| disp | input | DISP_W | Signed word displacement |
| taken | output | 1 | Branch is taken |
| annul_next | output | 1 | Squash the delay-slot instruction |
| target | output | ADDR_W | Branch target address |

## Verification
The assertions assume the inputs are known, non-X values in every cycle after reset. They compare registered outputs with the inputs of the previous cycle, so they only start after one clean cycle out of reset.

The stimulus applies inputs at the falling edge and holds them for a full cycle. It draws every field from $urandom, so all sixteen codes are used with arbitrary flag patterns, and is_branch, annul_bit and use_alt all toggle. Directed cases add the extreme displacements and differing flag sets.

// File: rtl/brc_pkg.sv
package brc_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } brc_flags_t;

   typedef enum logic [3:0] {
      BRC_NEVER = 4'd0,  BRC_EQ  = 4'd1,  BRC_LE  = 4'd2,  BRC_LT  = 4'd3,
      BRC_LEU   = 4'd4,  BRC_CS  = 4'd5,  BRC_NEG = 4'd6,  BRC_VS  = 4'd7,
      BRC_ALWAYS= 4'd8,  BRC_NE  = 4'd9,  BRC_GT  = 4'd10, BRC_GE  = 4'd11,
      BRC_GU    = 4'd12, BRC_CC  = 4'd13, BRC_POS = 4'd14, BRC_VC  = 4'd15
   } brc_cond_e;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
   import brc_pkg::*;
(
   input  brc_flags_t flags,
   input  logic [3:0] code,
   output logic       hit
);
   logic base;

   // Lower half defines the test; bit 3 inverts it (R3, R4)
   always_comb begin
      case (code[2:0])
         3'd0:    base = 1'b0;
         3'd1:    base = flags.z;
         3'd2:    base = flags.z | (flags.n ^ flags.v);
         3'd3:    base = flags.n ^ flags.v;
         3'd4:    base = flags.c | flags.z;
         3'd5:    base = flags.c;
         3'd6:    base = flags.n;
         default: base = flags.v;
      endcase
      hit = base ^ code[3];
   end

   always_comb begin
      if (code == BRC_ALWAYS) assert (hit) else $error("AST_ALWAYS_HITS");   // R4
      if (code == BRC_NEVER)  assert (!hit) else $error("AST_NEVER_MISSES"); // R3
   end
endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 22
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] target
);
   localparam int EXT_W = ADDR_W - DISP_W - 2;

   logic [ADDR_W-1:0] offset;

   generate
      if (EXT_W > 0) begin : g_ext
         assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
      end else begin : g_trunc
         assign offset = {disp[ADDR_W-3:0], 2'b00};
      end
   endgenerate

   assign target = pc + offset; // R10
endmodule

// File: rtl/brc_unit.sv
module brc_unit
   import brc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DISP_W  = 22,
   parameter bit ALT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_branch,
   input  logic [3:0]        cond_sel,
   input  logic              annul_bit,
   input  logic              use_alt,
   input  logic [3:0]        int_flags,
   input  logic [3:0]        alt_flags,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   output logic              taken,
   output logic              annul_next,
   output logic [ADDR_W-1:0] target
);
   localparam int MIN_ADDR_W = 8;

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("brc_unit: ADDR_W too small");
      end
      if (DISP_W < 2 || DISP_W > ADDR_W - 2) begin : g_bad_disp
         $error("brc_unit: DISP_W out of range");
      end
   endgenerate

   brc_flags_t sel_flags;
   logic       hit;
   logic       taken_d;
   logic       annul_d;
   logic [ADDR_W-1:0] target_d;
   logic       past_ok;

   generate
      if (ALT_EN) begin : g_alt
         assign sel_flags = use_alt ? brc_flags_t'(alt_flags) : brc_flags_t'(int_flags);
      end else begin : g_int_only
         logic unused_alt;
         assign unused_alt = use_alt ^ (^alt_flags);
         assign sel_flags  = brc_flags_t'(int_flags);
      end
   endgenerate

   brc_cond_eval u_eval (
      .flags (sel_flags),
      .code  (cond_sel),
      .hit   (hit)
   );

   brc_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
      .pc     (pc),
      .disp   (disp),
      .target (target_d)
   );

   assign taken_d = is_branch & hit;
   assign annul_d = is_branch & annul_bit & (~hit | (cond_sel == BRC_ALWAYS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken      <= 1'b0;
         annul_next <= 1'b0;
         target     <= '0;
         past_ok    <= 1'b0;
      end else begin
         taken      <= taken_d;
         annul_next <= annul_d;
         target     <= target_d;
         past_ok    <= 1'b1;
      end
   end

   AST_TAKEN_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && taken |-> $past(is_branch));                                    // R2
   AST_NO_ANNUL_WITHOUT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && annul_next |-> $past(annul_bit) && $past(is_branch));           // R5
   AST_UNTAKEN_ANNULS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(is_branch && annul_bit) && !taken |-> annul_next);        // R6
   AST_ALWAYS_SQUASHES: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(is_branch && annul_bit && cond_sel == 4'd8)
      |-> taken && annul_next);                                                  // R8
endmodule

// File: tb/brc_unit_test.sv
module brc_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        is_branch = 1'b0;
   logic [3:0]  cond_sel = '0;
   logic        annul_bit = 1'b0;
   logic        use_alt = 1'b0;
   logic [3:0]  int_flags = '0;
   logic [3:0]  alt_flags = '0;
   logic [31:0] pc = '0;
   logic [21:0] disp = '0;
   logic        taken, annul_next;
   logic [31:0] target;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   brc_unit uut (
      .clk(clk), .rst_n(rst_n), .is_branch(is_branch), .cond_sel(cond_sel),
      .annul_bit(annul_bit), .use_alt(use_alt), .int_flags(int_flags),
      .alt_flags(alt_flags), .pc(pc), .disp(disp),
      .taken(taken), .annul_next(annul_next), .target(target)
   );

   function automatic bit cond_hit(input logic [3:0] code, input logic [3:0] f);
      bit n, z, v, c, r;
      n = f[3]; z = f[2]; v = f[1]; c = f[0];
      case (code)
         4'd0:  r = 0;            4'd8:  r = 1;
         4'd1:  r = z;            4'd9:  r = !z;
         4'd2:  r = z | (n ^ v);  4'd10: r = !(z | (n ^ v));
         4'd3:  r = n ^ v;        4'd11: r = !(n ^ v);
         4'd4:  r = c | z;        4'd12: r = !(c | z);
         4'd5:  r = c;            4'd13: r = !c;
         4'd6:  r = n;            4'd14: r = !n;
         default: r = (code == 4'd7) ? v : !v;
      endcase
      return r;
   endfunction

   function automatic logic [31:0] exp_target(input logic [31:0] p, input logic [21:0] d);
      logic signed [31:0] sx;
      sx = {{10{d[21]}}, d};
      return p + 32'(sx * 4);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply_and_check(input bit br, input logic [3:0] cs, input bit an,
                                  input bit alt, input logic [3:0] fi, input logic [3:0] fa,
                                  input logic [31:0] p, input logic [21:0] d);
      bit h, et, ea;
      is_branch = br; cond_sel = cs; annul_bit = an; use_alt = alt;
      int_flags = fi; alt_flags = fa; pc = p; disp = d;
      h  = cond_hit(cs, alt ? fa : fi);
      et = br & h;
      ea = br & an & (!h | (cs == 4'd8));
      @(negedge clk);
      check(br ? "R3/R4/R9 taken" : "R2 taken idle", 32'(taken), 32'(et));
      if (!an)               check("R5 annul", 32'(annul_next), 32'(ea));
      else if (!br)          check("R2 annul idle", 32'(annul_next), 32'(ea));
      else if (cs == 4'd8)   check("R8 annul", 32'(annul_next), 32'(ea));
      else if (h)            check("R7 annul", 32'(annul_next), 32'(ea));
      else                   check("R6 annul", 32'(annul_next), 32'(ea));
      check("R10 target", target, exp_target(p, d));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      pc = 32'h1234_5678; disp = 22'h1; is_branch = 1'b1; cond_sel = 4'd8;
      repeat (3) @(negedge clk);
      check("R1 taken reset", 32'(taken), 0);
      check("R1 annul reset", 32'(annul_next), 0);
      check("R1 target reset", target, 0);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 taken first", 32'(taken), 0);

      // Directed corners
      apply_and_check(1, 4'd8, 1, 0, 4'h0, 4'h0, 32'h100, 22'h0);    // R8
      apply_and_check(1, 4'd0, 1, 0, 4'hF, 4'hF, 32'h100, 22'h0);    // R6 never
      apply_and_check(1, 4'd0, 0, 0, 4'hF, 4'hF, 32'h100, 22'h0);    // R5
      apply_and_check(0, 4'd8, 1, 0, 4'h0, 4'h0, 32'h200, 22'h4);    // R2
      apply_and_check(1, 4'd1, 1, 0, 4'h4, 4'h0, 32'h0, 22'h1FFFFF); // R7, max fwd
      apply_and_check(1, 4'd1, 1, 1, 4'h4, 4'h0, 32'h0, 22'h200000); // R9, max back
      apply_and_check(1, 4'd3, 0, 1, 4'h0, 4'h8, 32'hFFFF_FFF0, 22'h8); // R9 wrap R10
      apply_and_check(1, 4'd12, 1, 0, 4'h1, 4'h0, 32'h40, 22'h3FFFFF); // R4 gu

      for (int i = 0; i < 600; i++) begin
         apply_and_check(1'($urandom % 4 != 0), 4'($urandom), 1'($urandom),
                         1'($urandom), 4'($urandom), 4'($urandom),
                         $urandom, 22'($urandom));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule